// File: doc/BRIEF.md
# Multiplexed Address/Data Bus Sequencer

This block runs the external bus cycle of a 16-bit processor core. Each access the core requests becomes a four-phase cycle: T1, then T2, then T3, then T4. Two buses are driven during the cycle. The 20-bit address bus holds the address for all four phases. The 16-bit multiplexed bus carries the low address bits during T1. For T2 to T4 it carries write data on a write, and it floats on a read. Read data is captured from the multiplexed bus at the end of T3.

Accesses that hit the upper or the lower memory region can leave the multiplexed bus undriven during T1, which saves switching power. Each region has its own suppression bit, and both bits are loaded through a small write port. A strap input is sampled while reset is held. A low strap forces the address onto the multiplexed bus for every access, whatever the suppression bits say.

The sequencer states are PH_IDLE, PH_T1, PH_T2, PH_T3 and PH_T4. The transitions are:

- IDLE to T1 when a request is accepted.
- T1 to T2, T2 to T3 and T3 to T4 unconditionally.
- T4 to T1 when a new request is accepted.
- T4 to IDLE otherwise.

Top module: `mxbus_seq`

## Requirements
- R1: Once a request is accepted, the phases run T1, T2, T3, T4, one clock each. `done_o` is high in T4 and in no other phase.
- R2: With no suppression in force, T1 drives `mx_oe_o`=1 and `mx_o` = address bits [15:0].
- R3: `abus_o` equals the request address from T1 through T4, and it is 0 when idle.
- R4: A write on the configuration port loads the suppression bits from `cfg_wdata_i`: bit 0 for the upper region, bit 1 for the lower region. Both bits reset to 0, which means the address is driven.
- R5: `region_i` bit 0 flags an upper-region access and bit 1 flags a lower-region access. If the latched strap is 1 and the suppression bit of the flagged region is 1, then `mx_oe_o`=0 during T1.
- R6: If the strap was latched as 0, the address is driven in T1 for every access, whatever the suppression bits hold.
- R7: An access with `region_i`=2'b00 always drives the address in T1.
- R8: From T2 to T4, a write drives `mx_oe_o`=1 with `mx_o` = write data. A read holds `mx_oe_o`=0. `mx_o` is 0 whenever `mx_oe_o` is 0.
- R9: On a read, the value on `mx_i` at the clock edge that ends T3 appears on `rdata_o` from T4 onward. It stays there until the next read capture.
- R10: `ready_o` is high in IDLE and in T4. A request is accepted only then, so a request held high in T4 starts T1 on the very next cycle.
- R11: The strap is sampled on every clock edge while `rst_n` is low. It holds the last sampled value until the next reset.
- R12: The suppression decision is taken when the request is accepted. A configuration write on that same edge, or later, affects only later accesses.
- R13: In reset and right after it, the block is in IDLE: `mx_oe_o`=0, `mx_o`=0, `abus_o`=0, `done_o`=0, `ready_o`=1 and `rdata_o`=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| req_i | input | 1 | Access request from the core |
| wr_i | input | 1 | 1 for a write, 0 for a read |
| addr_i | input | 20 | Access address |
| wdata_i | input | 16 | Write data |
| region_i | input | 2 | Region hit flags: bit 0 upper, bit 1 lower |
| strap_i | input | 1 | Address-drive strap, sampled during reset |
| cfg_we_i | input | 1 | Configuration write strobe |
| cfg_wdata_i | input | 2 | New suppression bits: bit 0 upper, bit 1 lower |
| mx_i | input | 16 | Value read from the multiplexed bus |
| mx_o | output | 16 | Value driven onto the multiplexed bus |
| mx_oe_o | output | 1 | Output enable for the multiplexed bus |
| abus_o | output | 20 | Non-multiplexed address bus |
| rdata_o | output | 16 | Captured read data |
| done_o | output | 1 | Cycle completion pulse (T4) |
| ready_o | output | 1 | A request can be accepted this cycle |

## Verification
The bench goes after the cases where the T1 enable depends on several inputs at once.

- Each region is accessed with its own suppression bit set and with the other region's bit set. A design that decoded the wrong bit would float the bus for the wrong region.
- A configuration write lands on the same edge that accepts a request. A design that read the suppression bits live would change the cycle already in flight.
- A second reset is run with the strap low and both bits set. A design without the override would float the address.
- A request is held high across T4, and the read capture is timed against a changing `mx_i`. A design that dropped the back-to-back acceptance, or sampled one cycle off, would diverge from the reference model in the phase or the captured word.

// File: rtl/mxbus_pkg.sv
package mxbus_pkg;
    typedef enum logic [2:0] {
        PH_IDLE = 3'd0,
        PH_T1   = 3'd1,
        PH_T2   = 3'd2,
        PH_T3   = 3'd3,
        PH_T4   = 3'd4
    } phase_e;
endpackage

// File: rtl/mxbus_cfg.sv
module mxbus_cfg #(
    parameter int NREG = 2
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            strap_i,
    input  logic            cfg_we_i,
    input  logic [NREG-1:0] cfg_wdata_i,
    output logic            strap_q,
    output logic [NREG-1:0] sup_bits_q
);
    // Strap follows the pin on every edge while reset is held, then freezes.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            strap_q <= strap_i;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sup_bits_q <= '0;
        end else if (cfg_we_i) begin
            sup_bits_q <= cfg_wdata_i;
        end
    end

    // R11: strap does not move once reset is released
    a_r11_strap_hold: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) |-> $stable(strap_q));
endmodule

// File: rtl/mxbus_fsm.sv
module mxbus_fsm
    import mxbus_pkg::*;
(
    input  logic   clk,
    input  logic   rst_n,
    input  logic   req_i,
    output phase_e state_q,
    output logic   accept_o
);
    phase_e state_d;

    assign accept_o = req_i && (state_q == PH_IDLE || state_q == PH_T4);

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            PH_IDLE: state_d = accept_o ? PH_T1 : PH_IDLE;
            PH_T1:   state_d = PH_T2;
            PH_T2:   state_d = PH_T3;
            PH_T3:   state_d = PH_T4;
            PH_T4:   state_d = accept_o ? PH_T1 : PH_IDLE;
            default: state_d = PH_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= PH_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // R1: fixed phase order
    a_r1_t1_to_t2: assert property (@(posedge clk) disable iff (!rst_n)
        state_q == PH_T1 |=> state_q == PH_T2);
    a_r1_t3_to_t4: assert property (@(posedge clk) disable iff (!rst_n)
        state_q == PH_T3 |=> state_q == PH_T4);
    // R10: a request seen in idle starts T1 next cycle
    a_r10_idle_accept: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == PH_IDLE && req_i) |=> state_q == PH_T1);
endmodule

// File: rtl/mxbus_seq.sv
module mxbus_seq
    import mxbus_pkg::*;
#(
    parameter int ADDR_W = 20,
    parameter int DATA_W = 16,
    parameter int NREG   = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_i,
    input  logic              wr_i,
    input  logic [ADDR_W-1:0] addr_i,
    input  logic [DATA_W-1:0] wdata_i,
    input  logic [NREG-1:0]   region_i,
    input  logic              strap_i,
    input  logic              cfg_we_i,
    input  logic [NREG-1:0]   cfg_wdata_i,
    input  logic [DATA_W-1:0] mx_i,
    output logic [DATA_W-1:0] mx_o,
    output logic              mx_oe_o,
    output logic [ADDR_W-1:0] abus_o,
    output logic [DATA_W-1:0] rdata_o,
    output logic              done_o,
    output logic              ready_o
);
    localparam int MXA_W = (ADDR_W < DATA_W) ? ADDR_W : DATA_W;

    phase_e              state_q;
    logic                accept;
    logic                strap_q;
    logic [NREG-1:0]     sup_bits_q;
    logic [ADDR_W-1:0]   addr_q;
    logic [DATA_W-1:0]   wdata_q;
    logic                wr_q;
    logic                sup_q;
    logic [DATA_W-1:0]   rdata_q;
    logic [DATA_W-1:0]   addr_on_mx;

    mxbus_cfg #(.NREG(NREG)) u_cfg (
        .clk         (clk),
        .rst_n       (rst_n),
        .strap_i     (strap_i),
        .cfg_we_i    (cfg_we_i),
        .cfg_wdata_i (cfg_wdata_i),
        .strap_q     (strap_q),
        .sup_bits_q  (sup_bits_q)
    );

    mxbus_fsm u_fsm (
        .clk      (clk),
        .rst_n    (rst_n),
        .req_i    (req_i),
        .state_q  (state_q),
        .accept_o (accept)
    );

    // Request capture; the suppression decision is frozen here (R12).
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            addr_q  <= '0;
            wdata_q <= '0;
            wr_q    <= 1'b0;
            sup_q   <= 1'b0;
        end else if (accept) begin
            addr_q  <= addr_i;
            wdata_q <= wdata_i;
            wr_q    <= wr_i;
            sup_q   <= strap_q && |(region_i & sup_bits_q);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rdata_q <= '0;
        end else if (state_q == PH_T3 && !wr_q) begin
            rdata_q <= mx_i;
        end
    end

    always_comb begin
        addr_on_mx = '0;
        addr_on_mx[MXA_W-1:0] = addr_q[MXA_W-1:0];
    end

    // Output decode from the current phase.
    always_comb begin
        mx_o    = '0;
        mx_oe_o = 1'b0;
        abus_o  = '0;
        done_o  = 1'b0;
        ready_o = 1'b0;
        unique case (state_q)
            PH_IDLE: begin
                ready_o = 1'b1;
            end
            PH_T1: begin
                abus_o  = addr_q;
                mx_oe_o = !sup_q;
                mx_o    = sup_q ? '0 : addr_on_mx;
            end
            PH_T2, PH_T3: begin
                abus_o  = addr_q;
                mx_oe_o = wr_q;
                mx_o    = wr_q ? wdata_q : '0;
            end
            PH_T4: begin
                abus_o  = addr_q;
                mx_oe_o = wr_q;
                mx_o    = wr_q ? wdata_q : '0;
                done_o  = 1'b1;
                ready_o = 1'b1;
            end
            default: begin
                ready_o = 1'b0;
            end
        endcase
    end

    assign rdata_o = rdata_q;

    // R3: address bus steady through the data phase
    a_r3_abus_steady: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == PH_T2 || state_q == PH_T3 || state_q == PH_T4) |-> $stable(abus_o));
    // R6: low strap forces address drive in T1
    a_r6_strap_forces: assert property (@(posedge clk) disable iff (!rst_n)
        (!strap_q && state_q == PH_T1) |-> mx_oe_o);
    // R8: reads leave the bus floating in the data phase
    a_r8_read_float: assert property (@(posedge clk) disable iff (!rst_n)
        ((state_q == PH_T2 || state_q == PH_T3 || state_q == PH_T4) && !wr_q) |-> !mx_oe_o);
    // R8: a floating bus carries zeros
    a_r8_zero_when_off: assert property (@(posedge clk) disable iff (!rst_n)
        !mx_oe_o |-> mx_o == '0);
endmodule

// File: tb/mxbus_seq_tb.sv
module mxbus_seq_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_i = 1'b0, wr_i = 1'b0, strap_i = 1'b1;
    logic        cfg_we_i = 1'b0;
    logic [1:0]  cfg_wdata_i = '0, region_i = '0;
    logic [19:0] addr_i = '0;
    logic [15:0] wdata_i = '0, mx_i = '0;
    logic [15:0] mx_o, rdata_o;
    logic        mx_oe_o, done_o, ready_o;
    logic [19:0] abus_o;

    int n_chk = 0, n_fail = 0;
    int cyc = 0;

    always #2.5 clk = ~clk;

    mxbus_seq u_dut (
        .clk(clk), .rst_n(rst_n), .req_i(req_i), .wr_i(wr_i), .addr_i(addr_i),
        .wdata_i(wdata_i), .region_i(region_i), .strap_i(strap_i),
        .cfg_we_i(cfg_we_i), .cfg_wdata_i(cfg_wdata_i), .mx_i(mx_i),
        .mx_o(mx_o), .mx_oe_o(mx_oe_o), .abus_o(abus_o), .rdata_o(rdata_o),
        .done_o(done_o), .ready_o(ready_o)
    );

    // Behavioural reference model
    int          m_ph = 0;
    bit          m_wr = 0, m_sup = 0, m_strap = 0;
    bit [1:0]    m_dis = 0;
    bit [19:0]   m_addr = 0;
    bit [15:0]   m_wdata = 0, m_rd = 0;

    always @(posedge clk) begin
        if (!rst_n) begin
            m_ph = 0; m_dis = 0; m_strap = strap_i; m_rd = 0;
        end else begin
            if (m_ph == 3 && !m_wr) m_rd = mx_i;
            if (req_i && (m_ph == 0 || m_ph == 4)) begin
                m_sup   = m_strap && ((region_i[0] && m_dis[0]) || (region_i[1] && m_dis[1]));
                m_addr  = addr_i; m_wdata = wdata_i; m_wr = wr_i;
                m_ph    = 1;
            end else if (m_ph == 0 || m_ph == 4) begin
                m_ph = 0;
            end else begin
                m_ph = m_ph + 1;
            end
            if (cfg_we_i) m_dis = cfg_wdata_i;
        end
    end

    task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s cyc=%0d actual=%h expected=%h", tag, cyc, act, exp);
        end
    endtask

    // Compare against the model every cycle, away from the active edge
    always @(negedge clk) begin
        cyc++;
        mx_i <= 16'hC300 ^ 16'(cyc * 37);
        if (cyc > 1) begin
            bit        e_oe;
            bit [15:0] e_mx;
            string     t;
            e_oe = (m_ph == 1) ? !m_sup : (m_ph >= 2 && m_wr);
            e_mx = !e_oe ? 16'h0 : (m_ph == 1 ? m_addr[15:0] : m_wdata);
            if (!rst_n) t = "R13";
            else if (m_ph == 1) t = m_sup ? "R5" : (m_strap ? "R2" : "R6");
            else t = "R8";
            chk(mx_oe_o === e_oe, t, 32'(mx_oe_o), 32'(e_oe));
            chk(mx_o === e_mx, t, 32'(mx_o), 32'(e_mx));
            chk(abus_o === (m_ph != 0 ? m_addr : 20'h0), "R3", 32'(abus_o), 32'(m_ph != 0 ? m_addr : 20'h0));
            chk(done_o === (m_ph == 4), "R1", 32'(done_o), 32'(m_ph == 4));
            chk(ready_o === (m_ph == 0 || m_ph == 4), "R10", 32'(ready_o), 32'(m_ph == 0 || m_ph == 4));
            chk(rdata_o === m_rd, "R9", 32'(rdata_o), 32'(m_rd));
        end
    end

    // One access; checks the T1 enable against a literal expectation
    task automatic access(input bit w, input logic [19:0] a, input logic [15:0] d,
                          input logic [1:0] rg, input bit exp_oe, input string tag);
        @(negedge clk);
        req_i = 1'b1; wr_i = w; addr_i = a; wdata_i = d; region_i = rg;
        @(negedge clk);
        req_i = 1'b0;
        chk(mx_oe_o === exp_oe, tag, 32'(mx_oe_o), 32'(exp_oe));
        repeat (4) @(negedge clk);
    endtask

    task automatic cfg_write(input logic [1:0] v);
        @(negedge clk);
        cfg_we_i = 1'b1; cfg_wdata_i = v;
        @(negedge clk);
        cfg_we_i = 1'b0;
    endtask

    task automatic run_all();
        strap_i = 1'b1;
        repeat (3) @(negedge clk);
        // R13: reset state
        chk(ready_o === 1'b1 && mx_oe_o === 1'b0 && abus_o === 20'h0, "R13", 32'(abus_o), 0);
        rst_n = 1'b1;
        strap_i = 1'b0;                  // R11: pin change after reset is ignored
        @(negedge clk);
        chk(rdata_o === 16'h0 && done_o === 1'b0, "R13", 32'(rdata_o), 0);
        access(1'b1, 20'hABCDE, 16'h1234, 2'b00, 1'b1, "R7");
        access(1'b0, 20'hF0F0F, 16'h0, 2'b01, 1'b1, "R4");   // bits reset to 0
        cfg_write(2'b01);
        access(1'b0, 20'hF1234, 16'h0, 2'b01, 1'b0, "R5");   // upper suppressed
        access(1'b1, 20'h01234, 16'h5A5A, 2'b10, 1'b1, "R4"); // lower bit clear
        access(1'b0, 20'h55555, 16'h0, 2'b00, 1'b1, "R7");
        access(1'b0, 20'h0, 16'h0, 2'b00, 1'b1, "R11");      // strap held high
        cfg_write(2'b10);
        access(1'b1, 20'h00042, 16'hBEEF, 2'b10, 1'b0, "R5");
        access(1'b0, 20'hFFFF0, 16'h0, 2'b01, 1'b1, "R4");
        // R12: config write on the accepting edge does not touch this cycle
        @(negedge clk);
        req_i = 1'b1; wr_i = 1'b0; addr_i = 20'hE0000; region_i = 2'b01;
        cfg_we_i = 1'b1; cfg_wdata_i = 2'b01;
        @(negedge clk);
        req_i = 1'b0; cfg_we_i = 1'b0;
        chk(mx_oe_o === 1'b1, "R12", 32'(mx_oe_o), 1);
        repeat (4) @(negedge clk);
        access(1'b0, 20'hE0004, 16'h0, 2'b01, 1'b0, "R12");
        // R10: back-to-back requests
        @(negedge clk);
        req_i = 1'b1; wr_i = 1'b1; addr_i = 20'h12345; wdata_i = 16'h7777; region_i = 2'b00;
        repeat (3) @(negedge clk);
        addr_i = 20'h6789A; wr_i = 1'b0;
        @(negedge clk);                  // T4, request pending
        chk(done_o === 1'b1 && ready_o === 1'b1, "R10", 32'(done_o), 1);
        @(negedge clk);
        req_i = 1'b0;
        chk(abus_o === 20'h6789A, "R10", 32'(abus_o), 32'h6789A);
        repeat (5) @(negedge clk);
        // R6: strap low at reset overrides the suppression bits
        rst_n = 1'b0; strap_i = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1; strap_i = 1'b1;
        cfg_write(2'b11);
        access(1'b0, 20'hF8000, 16'h0, 2'b01, 1'b1, "R6");
        access(1'b1, 20'h00800, 16'h3C3C, 2'b10, 1'b1, "R6");
        repeat (2) @(negedge clk);
    endtask

    initial begin
        fork
            run_all();
            begin
                repeat (5000) @(posedge clk);
                n_chk++; n_fail++;
                $display("FAIL watchdog expired");
            end
        join_any
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule